// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs one 8-bit successive approximation conversion against analog parts outside it: a sample-and-hold, a capacitive DAC and a comparator. Each conversion starts with a start strobe. The block holds its sample-enable output high while the input is captured. It then drives a trial code to the DAC and reads back one comparator bit, which is high when the held input is at or above the level of that trial code. It decides one result bit per slot, beginning with the most significant bit.

A conversion always takes exactly 32 clocks on a fixed schedule, counted from the clock edge that accepts the start:

| Cycles | Phase |
|---|---|
| 0 to 11 | sample |
| 12 to 15 | most significant bit |
| 16 to 29 | the other seven bits, two cycles each, in falling bit order |
| 30 and 31 | closing phase |

In cycle 31 the block pulses `done_o` and presents the finished code. It keeps that code until the next conversion finishes. The surrounding logic issues a start, waits for `done_o` and reads `result_o`.

Top module: `sar_engine`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `sample_en_o`, `done_o`, `trial_o` and `result_o` are all zero.
- R2: A start strobe seen at a clock edge while the block is idle begins a conversion. `sample_en_o` is then high in cycles 0 to 11 counted from that edge, and low at all other times.
- R3: `trial_o` is 0x00 during the sample phase and 0x80 in cycles 12 to 15. In every later bit slot it holds the bits already decided, with the bit under test set to 1 and all lower bits set to 0.
- R4: A bit under test stays 1 if `cmp_above_i` is high in the last cycle of its slot and is cleared if it is low. Those last cycles are cycle 15 for bit 7 and cycles 17, 19, ..., 29 for bits 6 down to 0. The comparator value in any other cycle has no effect.
- R5: The result is the binary code of the held input level: 0x00 is the bottom of the reference range and 0xFF is the top. When the comparator reports input ≥ trial level, the result is the largest code whose level does not exceed the input.
- R6: `done_o` is high for exactly one clock, in cycle 31. `result_o` takes the new code in that same cycle and changes at no other time.
- R7: A start strobe that arrives while a conversion is running, including in cycle 31, is ignored. It does not restart the conversion and does not queue a new one.
- R8: If start is held high, a new conversion is accepted in the idle cycle right after each one ends, so conversions repeat every 33 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| start_i | input | 1 | Start strobe, accepted only when idle |
| cmp_above_i | input | 1 | Comparator: held input at or above the current trial level |
| sample_en_o | output | 1 | High during the sample phase |
| trial_o | output | 8 | Trial code driven to the DAC |
| result_o | output | 8 | Final conversion code |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bound checker follows the schedule from the ports and checks on every cycle:
- the single-cycle done pulse and its position in the schedule;
- that the result changes only with done;
- that the trial code is zero while sampling and 0x80 once sampling ends;
- that a rejected bit lowers the trial code, an accepted bit never lowers it, and the trial code is still outside decision cycles.

Only the bench scenarios can show the rest:
- that each final code is correct for inputs at the bottom and top of the range, at exact code boundaries and between codes;
- that comparator noise outside the decision cycles has no effect;
- that starts held through a whole conversion, or held continuously, give exactly the expected number of conversions.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Coarse phase of one conversion, decoded from the cycle counter.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_BITS   = 2'd2,
    PH_CLOSE  = 2'd3
  } phase_t;

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int NBITS      = 8,
  parameter int SAMPLE_CYC = 12,
  parameter int FIRST_CYC  = 4,
  parameter int BIT_CYC    = 2,
  parameter int END_CYC    = 2,
  localparam int IDX_W     = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             sample_o,
  output logic             load_msb_o,
  output logic             decide_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             capture_o,
  output logic             last_o
);

  localparam int TOTAL     = SAMPLE_CYC + FIRST_CYC + (NBITS - 1) * BIT_CYC + END_CYC;
  localparam int CNT_W     = $clog2(TOTAL);
  localparam int FIRST_END = SAMPLE_CYC + FIRST_CYC;
  localparam int BITS_END  = FIRST_END + (NBITS - 1) * BIT_CYC;

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             slot_last;
  sar_pkg::phase_t  phase;

  // Next-state logic for the busy flag and the cycle counter.
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (cnt_q == CNT_W'(TOTAL - 1)) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = busy_q | start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // Work out which bit slot the counter is in, and whether this is the
  // slot's last cycle.
  always_comb begin
    int c;
    int off;
    c         = int'(cnt_q);
    off       = 0;
    bit_idx_o = IDX_W'(NBITS - 1);
    slot_last = 1'b0;
    if (c >= SAMPLE_CYC && c < FIRST_END) begin
      slot_last = (c == FIRST_END - 1);
    end else if (c >= FIRST_END && c < BITS_END) begin
      off       = c - FIRST_END;
      bit_idx_o = IDX_W'(NBITS - 2 - off / BIT_CYC);
      slot_last = ((off % BIT_CYC) == BIT_CYC - 1);
    end
  end

  always_comb begin
    if (!busy_q)                          phase = sar_pkg::PH_IDLE;
    else if (int'(cnt_q) < SAMPLE_CYC)    phase = sar_pkg::PH_SAMPLE;
    else if (int'(cnt_q) < BITS_END)      phase = sar_pkg::PH_BITS;
    else                                  phase = sar_pkg::PH_CLOSE;
  end

  assign accept_o   = start_i & ~busy_q;
  assign sample_o   = (phase == sar_pkg::PH_SAMPLE);
  assign load_msb_o = busy_q && (int'(cnt_q) == SAMPLE_CYC - 1);
  assign decide_o   = (phase == sar_pkg::PH_BITS) && slot_last;
  assign capture_o  = (phase == sar_pkg::PH_CLOSE) && (int'(cnt_q) == TOTAL - 2);
  assign last_o     = busy_q && (int'(cnt_q) == TOTAL - 1);

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int NBITS  = 8,
  localparam int IDX_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_msb_i,
  input  logic             decide_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] trial_o
);

  logic [NBITS-1:0] trial_q, trial_d;
  logic             upd_en;

  // Each bit works out its own next value from the shared slot index.
  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    logic nxt;
    always_comb begin
      nxt = trial_q[g];
      if (clear_i) begin
        nxt = 1'b0;
      end else if (load_msb_i) begin
        nxt = (g == NBITS - 1);
      end else if (decide_i) begin
        if (int'(bit_idx_i) == g)          nxt = cmp_i;
        else if (int'(bit_idx_i) == g + 1) nxt = 1'b1;
      end
    end
    assign trial_d[g] = nxt;
  end

  assign upd_en = clear_i | load_msb_i | decide_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trial_q <= '0;
    else if (upd_en) trial_q <= trial_d;
  end

  assign trial_o = trial_q;

endmodule

// File: rtl/sar_result_hold.sv
module sar_result_hold #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [NBITS-1:0] code_i,
  output logic [NBITS-1:0] result_o
);

  logic [NBITS-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         res_q <= '0;
    else if (capture_i) res_q <= code_i;
  end

  assign result_o = res_q;

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int NBITS      = 8,
  parameter int SAMPLE_CYC = 12,
  parameter int FIRST_CYC  = 4,
  parameter int BIT_CYC    = 2,
  parameter int END_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_above_i,
  output logic             sample_en_o,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] result_o,
  output logic             done_o
);

  localparam int IDX_W = $clog2(NBITS);

  logic             accept;
  logic             load_msb;
  logic             decide;
  logic [IDX_W-1:0] bit_idx;
  logic             capture;
  logic             last;
  logic [NBITS-1:0] trial;

  sar_sequencer #(
    .NBITS(NBITS), .SAMPLE_CYC(SAMPLE_CYC), .FIRST_CYC(FIRST_CYC),
    .BIT_CYC(BIT_CYC), .END_CYC(END_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .accept_o   (accept),
    .sample_o   (sample_en_o),
    .load_msb_o (load_msb),
    .decide_o   (decide),
    .bit_idx_o  (bit_idx),
    .capture_o  (capture),
    .last_o     (last)
  );

  sar_trial_reg #(.NBITS(NBITS)) u_trial (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (accept),
    .load_msb_i (load_msb),
    .decide_i   (decide),
    .bit_idx_i  (bit_idx),
    .cmp_i      (cmp_above_i),
    .trial_o    (trial)
  );

  sar_result_hold #(.NBITS(NBITS)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .code_i    (trial),
    .result_o  (result_o)
  );

  assign trial_o = trial;
  assign done_o  = last;

endmodule

// File: rtl/sar_engine_chk.sv
module sar_engine_chk #(
  parameter int NBITS      = 8,
  parameter int SAMPLE_CYC = 12,
  parameter int FIRST_CYC  = 4,
  parameter int BIT_CYC    = 2,
  parameter int END_CYC    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cmp_above_i,
  input logic             sample_en_o,
  input logic [NBITS-1:0] trial_o,
  input logic [NBITS-1:0] result_o,
  input logic             done_o
);

  localparam int TOTAL     = SAMPLE_CYC + FIRST_CYC + (NBITS - 1) * BIT_CYC + END_CYC;
  localparam int CNT_W     = $clog2(TOTAL) + 1;
  localparam int FIRST_END = SAMPLE_CYC + FIRST_CYC;
  localparam int BITS_END  = FIRST_END + (NBITS - 1) * BIT_CYC;

  logic             cbusy_q;
  logic [CNT_W-1:0] ccnt_q;
  logic             cdecide;

  // Independent view of the schedule, rebuilt from the ports only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbusy_q <= 1'b0;
      ccnt_q  <= '0;
    end else if (!cbusy_q && start_i) begin
      cbusy_q <= 1'b1;
      ccnt_q  <= '0;
    end else if (cbusy_q) begin
      if (done_o) cbusy_q <= 1'b0;
      ccnt_q <= ccnt_q + 1'b1;
    end
  end

  always_comb begin
    int c;
    c       = int'(ccnt_q);
    cdecide = 1'b0;
    if (cbusy_q) begin
      if (c == FIRST_END - 1) cdecide = 1'b1;
      else if (c >= FIRST_END && c < BITS_END)
        cdecide = (((c - FIRST_END) % BIT_CYC) == BIT_CYC - 1);
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cbusy_q && int'(ccnt_q) == TOTAL - 1));

  p_result_moves_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);

  p_sample_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_en_o) |-> $past(start_i));

  p_sample_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> (cbusy_q && int'(ccnt_q) < SAMPLE_CYC));

  p_trial_zero_sampling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> (trial_o == '0));

  p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en_o) |-> (trial_o == {1'b1, {(NBITS-1){1'b0}}}));

  p_reject_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cdecide && !cmp_above_i) |=> (trial_o < $past(trial_o)));

  p_accept_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cdecide && cmp_above_i) |=> (trial_o >= $past(trial_o)));

  p_trial_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cbusy_q && !cdecide && int'(ccnt_q) != SAMPLE_CYC - 1) |=> $stable(trial_o));

  p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cbusy_q && start_i) |=> !$rose(sample_en_o));

endmodule

bind sar_engine sar_engine_chk #(
  .NBITS(NBITS), .SAMPLE_CYC(SAMPLE_CYC), .FIRST_CYC(FIRST_CYC),
  .BIT_CYC(BIT_CYC), .END_CYC(END_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmp_above_i (cmp_above_i),
  .sample_en_o (sample_en_o),
  .trial_o     (trial_o),
  .result_o    (result_o),
  .done_o      (done_o)
);

// File: tb/sar_engine_tb.sv
module sar_engine_tb;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       cmp_above_i;
  logic       sample_en_o;
  logic [7:0] trial_o;
  logic [7:0] result_o;
  logic       done_o;

  sar_engine u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_above_i (cmp_above_i),
    .sample_en_o (sample_en_o),
    .trial_o     (trial_o),
    .result_o    (result_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Reference model: accepted level plus the weight now under test.
  bit m_busy;
  int m_k, m_level, m_weight, m_result;
  int vin;        // input level on a 0..1023 scale, 4 steps per code
  bit noise;      // invert the comparator outside decision cycles
  int done_cnt;
  int rise_cnt;
  bit prev_sample;

  function automatic bit is_decide(int k);
    return (k == 15) || (k >= 17 && k <= 29 && (k % 2) == 1);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_level = 0; m_weight = 0; m_result = 0;
    end else if (m_busy) begin
      if (m_k == 11) m_weight = 128;
      if (is_decide(m_k)) begin
        if (cmp_above_i) m_level = m_level + m_weight;
        m_weight = m_weight / 2;
      end
      if (m_k == 30) m_result = m_level;
      if (m_k == 31) m_busy = 0;
      else m_k++;
    end else if (start_i) begin
      m_busy = 1; m_k = 0; m_level = 0; m_weight = 0;
    end
  end

  // Compare every cycle, then drive the comparator for this cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 sample_en", int'(sample_en_o), int'(m_busy && m_k < 12));
      check("R3 trial", int'(trial_o), m_level + m_weight);
      check("R6 done", int'(done_o), int'(m_busy && m_k == 31));
      check("R6 result", int'(result_o), m_result);
      if (m_busy && m_k == 31) begin
        check("R5 final code", int'(result_o), vin / 4);
        done_cnt++;
      end
      if (sample_en_o && !prev_sample) rise_cnt++;
      prev_sample = sample_en_o;
    end
    cmp_above_i = (vin >= (m_level + m_weight) * 4)
                  ^ (noise && !(m_busy && is_decide(m_k)));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  task automatic convert(int v, bit nz);
    @(negedge clk);
    vin = v; noise = nz; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (34) @(negedge clk);
    check("R6 result held", int'(result_o), v / 4);
    check("R6 done low after", int'(done_o), 0);
  endtask

  initial begin
    int d0, r0;
    rst_n = 1'b0; start_i = 1'b0; vin = 0; noise = 0;
    done_cnt = 0; rise_cnt = 0; prev_sample = 0;
    repeat (3) @(negedge clk);
    check("R1 sample_en in reset", int'(sample_en_o), 0);
    check("R1 trial in reset", int'(trial_o), 0);
    check("R1 result in reset", int'(result_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 trial after release", int'(trial_o), 0);

    // R4/R5: several levels, bounds, code edges, with and without noise
    convert(614, 1'b0);
    convert(0, 1'b0);
    convert(1023, 1'b0);
    convert(512, 1'b1);
    convert(511, 1'b1);
    convert(3, 1'b0);
    convert(1000, 1'b1);
    convert(341, 1'b1);

    // R7: start held during almost the whole conversion, released in cycle 30
    d0 = done_cnt; r0 = rise_cnt;
    @(negedge clk);
    vin = 300; noise = 0; start_i = 1'b1;
    repeat (31) @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 one conversion", done_cnt - d0, 1);
    check("R7 one sample phase", rise_cnt - r0, 1);

    // R7: a single start pulse in cycle 31 is dropped
    d0 = done_cnt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (31) @(negedge clk);
    check("R7 done in cycle 31", int'(done_o), 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 no restart", int'(sample_en_o), 0);
    check("R7 pulse count", done_cnt - d0, 1);

    // R8: continuous start gives a conversion every 33 clocks
    d0 = done_cnt; r0 = rise_cnt;
    vin = 777;
    start_i = 1'b1;
    repeat (99) @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    check("R8 back-to-back conversions", done_cnt - d0, 3);
    check("R8 back-to-back samples", rise_cnt - r0, 3);

    // R1: reset in the middle of a conversion
    vin = 900;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (16) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 trial mid reset", int'(trial_o), 0);
    check("R1 result mid reset", int'(result_o), 0);
    check("R1 sample mid reset", int'(sample_en_o), 0);
    check("R1 done mid reset", int'(done_o), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    prev_sample = 0;
    convert(900, 1'b1);

    summary();
  end

endmodule